// File: doc/BRIEF.md
# Debug Entry Priority Controller

This block decides when a processor core drops into debug state and in which processor mode it lands there. A halt request from the debugger, a breakpoint hit and a watchpoint hit all trigger debug entry. When one of them arrives together with a pending interrupt or with a data abort on a watchpointed access, debug entry still wins. The core enters debug state in the mode of the event it overrode, and that event is recorded in a sticky flag instead of being lost.

While the core is in debug state, interrupts are masked. The debugger reads a small status word to learn why the core stopped and which events were set aside. It can clear the recorded events with a pulse. A restart pulse leaves debug state, and the interrupt mask is then held for one more cycle before interrupts are allowed again.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When `in_debug_o` is 0 and any of `halt_req_i`, `bkpt_hit_i` or `wpt_hit_i` is 1 at a rising clock edge, `in_debug_o` and `irq_mask_o` are both 1 after that edge.
- R2: At debug entry with `irq_i` 1, `fiq_i` 0 and no watchpointed abort, `mode_o` becomes 5'b10010 (IRQ) and `irq_kept_o` becomes 1.
- R3: At debug entry with `fiq_i` 1 and no watchpointed abort, `mode_o` becomes 5'b10001 (FIQ), even when `irq_i` is also 1. `fiq_kept_o` becomes 1, and `irq_kept_o` follows `irq_i`.
- R4: At debug entry with `wpt_hit_i` and `dabort_i` both 1, `mode_o` becomes 5'b10111 (abort) and `abt_kept_o` becomes 1. This outranks both interrupts, and any pending interrupt is still recorded in its own flag.
- R5: Outside debug state `mode_o` is 5'b10000 (normal). This is also the entry mode when no interrupt and no watchpointed abort are pending. A `dabort_i` without `wpt_hit_i` is not recorded. After reset, every flag is 0 and `mode_o` is normal.
- R6: Once entered, debug state holds until `restart_i` is seen. Further triggers, interrupts and aborts inside debug state change neither `mode_o` nor the recorded flags.
- R7: `restart_i` in debug state clears `in_debug_o` and all recorded flags after the next edge and sets `mode_o` to normal. `irq_mask_o` stays 1 for exactly that one cycle and is 0 from the following one.
- R8: `clr_kept_i` clears all recorded flags after the next edge without leaving debug state. `restart_i` outside debug state has no effect.
- R9: `status_o` reads {`abt_kept_o`, `fiq_kept_o`, `irq_kept_o`, `in_debug_o`}, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Debugger halt request |
| bkpt_hit_i | input | 1 | Instruction breakpoint hit |
| wpt_hit_i | input | 1 | Data watchpoint hit |
| irq_i | input | 1 | Normal interrupt pending |
| fiq_i | input | 1 | Fast interrupt pending |
| dabort_i | input | 1 | Data abort on the current access |
| restart_i | input | 1 | Leave debug state |
| clr_kept_i | input | 1 | Clear the recorded-event flags |
| in_debug_o | output | 1 | Core is in debug state |
| mode_o | output | 5 | Processor mode code to run in |
| irq_mask_o | output | 1 | Interrupt disable to the core |
| irq_kept_o | output | 1 | An IRQ was overridden by debug entry |
| fiq_kept_o | output | 1 | An FIQ was overridden by debug entry |
| abt_kept_o | output | 1 | A watchpointed data abort was overridden |
| status_o | output | 4 | Debugger-readable status word |

## Verification
Some rules are checked by the assertions on every cycle. These are the entry response to a trigger, the mode chosen for each kind of overridden event, the freezing of mode and flags inside debug state, the one-cycle interrupt-mask tail after restart, and the effect of the clear pulse. Other behaviour shows up only in the bench's scenarios against its own model. That covers a trigger coinciding with IRQ, FIQ and an abort all at once, an abort with no watchpoint hit, a restart or clear outside debug state, and long random runs of entries and exits.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int MODE_W  = 5;
  localparam int KEPT_N  = 3;
  localparam int K_IRQ   = 0;
  localparam int K_FIQ   = 1;
  localparam int K_ABT   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_ABT = 5'b10111
  } cpu_mode_e;

  // Mode on debug entry: a watchpointed abort beats FIQ, FIQ beats IRQ.
  function automatic cpu_mode_e pick_entry_mode(input logic fiq,
                                                input logic irq,
                                                input logic wpt_abort);
    if (wpt_abort)  return MODE_ABT;
    else if (fiq)   return MODE_FIQ;
    else if (irq)   return MODE_IRQ;
    else            return MODE_USR;
  endfunction

  // Which overridden events get recorded at entry.
  function automatic logic [KEPT_N-1:0] entry_kept_bits(input logic fiq,
                                                        input logic irq,
                                                        input logic wpt_abort);
    logic [KEPT_N-1:0] b;
    b        = '0;
    b[K_IRQ] = irq;
    b[K_FIQ] = fiq;
    b[K_ABT] = wpt_abort;
    return b;
  endfunction
endpackage

// File: rtl/dbg_trigger_arb.sv
module dbg_trigger_arb
  import dbg_entry_pkg::*;
(
  input  logic              halt_req,
  input  logic              bkpt_hit,
  input  logic              wpt_hit,
  input  logic              irq,
  input  logic              fiq,
  input  logic              dabort,
  input  logic              in_debug,
  output logic              enter,
  output cpu_mode_e         entry_mode,
  output logic [KEPT_N-1:0] entry_kept
);
  logic any_trig;
  logic wpt_abort;

  always_comb begin
    any_trig   = halt_req | bkpt_hit | wpt_hit;
    wpt_abort  = wpt_hit & dabort;
    enter      = any_trig & ~in_debug;
    entry_mode = pick_entry_mode(fiq, irq, wpt_abort);
    entry_kept = entry_kept_bits(fiq, irq, wpt_abort);
  end
endmodule

// File: rtl/dbg_state_ctrl.sv
module dbg_state_ctrl
  import dbg_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter,
  input  logic      restart,
  input  cpu_mode_e entry_mode,
  output logic      in_debug,
  output cpu_mode_e mode,
  output logic      irq_mask,
  output logic      leave
);
  logic exit_tail;

  assign leave    = in_debug & restart;
  assign irq_mask = in_debug | exit_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_debug  <= 1'b0;
      mode      <= MODE_USR;
      exit_tail <= 1'b0;
    end else begin
      exit_tail <= leave;
      if (enter) begin
        in_debug <= 1'b1;
        mode     <= entry_mode;
      end else if (leave) begin
        in_debug <= 1'b0;
        mode     <= MODE_USR;
      end
    end
  end
endmodule

// File: rtl/dbg_kept_flags.sv
module dbg_kept_flags
  import dbg_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              leave,
  input  logic              clr,
  input  logic [KEPT_N-1:0] entry_kept,
  output logic [KEPT_N-1:0] kept
);
  for (genvar i = 0; i < KEPT_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            kept[i] <= 1'b0;
      else if (enter)        kept[i] <= entry_kept[i];
      else if (leave || clr) kept[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req_i,
  input  logic              bkpt_hit_i,
  input  logic              wpt_hit_i,
  input  logic              irq_i,
  input  logic              fiq_i,
  input  logic              dabort_i,
  input  logic              restart_i,
  input  logic              clr_kept_i,
  output logic              in_debug_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_mask_o,
  output logic              irq_kept_o,
  output logic              fiq_kept_o,
  output logic              abt_kept_o,
  output logic [KEPT_N:0]   status_o
);
  logic              enter_w;
  logic              leave_w;
  cpu_mode_e         entry_mode_w;
  cpu_mode_e         mode_w;
  logic [KEPT_N-1:0] entry_kept_w;
  logic [KEPT_N-1:0] kept_w;

  dbg_trigger_arb u_arb (
    .halt_req   (halt_req_i),
    .bkpt_hit   (bkpt_hit_i),
    .wpt_hit    (wpt_hit_i),
    .irq        (irq_i),
    .fiq        (fiq_i),
    .dabort     (dabort_i),
    .in_debug   (in_debug_o),
    .enter      (enter_w),
    .entry_mode (entry_mode_w),
    .entry_kept (entry_kept_w)
  );

  dbg_state_ctrl u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (enter_w),
    .restart    (restart_i),
    .entry_mode (entry_mode_w),
    .in_debug   (in_debug_o),
    .mode       (mode_w),
    .irq_mask   (irq_mask_o),
    .leave      (leave_w)
  );

  dbg_kept_flags u_kept (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (enter_w),
    .leave      (leave_w),
    .clr        (clr_kept_i),
    .entry_kept (entry_kept_w),
    .kept       (kept_w)
  );

  assign mode_o     = mode_w;
  assign irq_kept_o = kept_w[K_IRQ];
  assign fiq_kept_o = kept_w[K_FIQ];
  assign abt_kept_o = kept_w[K_ABT];
  assign status_o   = {kept_w, in_debug_o};
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk
  import dbg_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wpt_hit_i,
  input logic              irq_i,
  input logic              fiq_i,
  input logic              dabort_i,
  input logic              restart_i,
  input logic              clr_kept_i,
  input logic              enter_w,
  input logic              in_debug_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              irq_mask_o,
  input logic              irq_kept_o,
  input logic              fiq_kept_o,
  input logic              abt_kept_o
);
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_w |=> in_debug_o && irq_mask_o); // R1

  AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_w && irq_i && !fiq_i && !(wpt_hit_i && dabort_i) |=> mode_o == MODE_IRQ && irq_kept_o); // R2

  AST_FIQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_w && fiq_i && !(wpt_hit_i && dabort_i) |=> mode_o == MODE_FIQ && fiq_kept_o); // R3

  AST_ABT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_w && wpt_hit_i && dabort_i |=> mode_o == MODE_ABT && abt_kept_o); // R4

  AST_NORMAL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug_o |-> mode_o == MODE_USR); // R5

  AST_HOLD_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug_o && !restart_i && !clr_kept_i |=> in_debug_o && $stable(mode_o)
      && $stable({irq_kept_o, fiq_kept_o, abt_kept_o})); // R6

  AST_EXIT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug_o && restart_i |=> !in_debug_o && irq_mask_o
      && !irq_kept_o && !fiq_kept_o && !abt_kept_o); // R7

  AST_MASK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug_o && !$past(in_debug_o) |-> !irq_mask_o); // R7

  AST_CLEAR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug_o && clr_kept_i && !restart_i |=> in_debug_o
      && !irq_kept_o && !fiq_kept_o && !abt_kept_o); // R8
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wpt_hit_i  (wpt_hit_i),
  .irq_i      (irq_i),
  .fiq_i      (fiq_i),
  .dabort_i   (dabort_i),
  .restart_i  (restart_i),
  .clr_kept_i (clr_kept_i),
  .enter_w    (enter_w),
  .in_debug_o (in_debug_o),
  .mode_o     (mode_o),
  .irq_mask_o (irq_mask_o),
  .irq_kept_o (irq_kept_o),
  .fiq_kept_o (fiq_kept_o),
  .abt_kept_o (abt_kept_o)
);

// File: tb/tb_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt, bkpt, wpt, irq, fiq, dab, rst_go, clr;
  logic       dbg_o, mask_o, irqk_o, fiqk_o, abtk_o;
  logic [4:0] mode_o;
  logic [3:0] stat_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model state
  logic       m_dbg, m_tail, m_irqk, m_fiqk, m_abtk;
  logic [4:0] m_mode;

  always #10 clk = ~clk;

  dbg_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .halt_req_i(halt), .bkpt_hit_i(bkpt), .wpt_hit_i(wpt),
    .irq_i(irq), .fiq_i(fiq), .dabort_i(dab),
    .restart_i(rst_go), .clr_kept_i(clr),
    .in_debug_o(dbg_o), .mode_o(mode_o), .irq_mask_o(mask_o),
    .irq_kept_o(irqk_o), .fiq_kept_o(fiqk_o), .abt_kept_o(abtk_o),
    .status_o(stat_o)
  );

  function automatic logic [4:0] exp_mode(logic f, logic i, logic w, logic d);
    if (w && d) return 5'b10111;
    if (f)      return 5'b10001;
    if (i)      return 5'b10010;
    return 5'b10000;
  endfunction

  task automatic model_step();
    if (!m_dbg && (halt || bkpt || wpt)) begin
      m_dbg  = 1'b1;
      m_mode = exp_mode(fiq, irq, wpt, dab);
      m_irqk = irq; m_fiqk = fiq; m_abtk = wpt && dab;
      m_tail = 1'b0;
    end else if (m_dbg && rst_go) begin
      m_dbg = 1'b0; m_mode = 5'b10000;
      m_irqk = 0; m_fiqk = 0; m_abtk = 0;
      m_tail = 1'b1;
    end else begin
      m_tail = 1'b0;
      if (clr) begin m_irqk = 0; m_fiqk = 0; m_abtk = 0; end
    end
  endtask

  task automatic compare(string tag);
    logic [12:0] act, exp;
    act = {dbg_o, mask_o, mode_o, irqk_o, fiqk_o, abtk_o, stat_o[3:1]};
    exp = {m_dbg, m_dbg | m_tail, m_mode, m_irqk, m_fiqk, m_abtk, m_abtk, m_fiqk, m_irqk};
    n_checks++;
    if (act !== exp || stat_o[0] !== m_dbg) begin
      n_fail++;
      $display("FAIL %s: dbg/mask/mode/irqk/fiqk/abtk/stat act=%b st=%b exp=%b dbg=%b",
               tag, act, stat_o, exp, m_dbg);
    end
  endtask

  task automatic drive(logic h, logic b, logic w, logic i, logic f, logic d,
                       logic r, logic c);
    halt = h; bkpt = b; wpt = w; irq = i; fiq = f; dab = d; rst_go = r; clr = c;
  endtask

  // Apply inputs for one edge, update model, check 2 ns after the edge.
  task automatic step(string tag);
    @(posedge clk);
    model_step();
    #2;
    compare(tag);
    drive(0,0,0,0,0,0,0,0);
  endtask

  task automatic exit_debug(string tag);
    drive(0,0,0,0,0,0,1,0); step(tag);   // R7 mask tail cycle
    step(tag);                           // R7 mask released
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        n_checks++; n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    drive(0,0,0,0,0,0,0,0);
    m_dbg = 0; m_tail = 0; m_irqk = 0; m_fiqk = 0; m_abtk = 0; m_mode = 5'b10000;
    repeat (3) @(posedge clk);
    #2;
    compare("R5 reset");
    rst_n = 1'b1;
    step("R5 idle");

    // R1 each trigger alone, normal mode
    drive(1,0,0,0,0,0,0,0); step("R1 halt entry"); exit_debug("R7 exit");
    drive(0,1,0,0,0,0,0,0); step("R1 bkpt entry"); exit_debug("R7 exit");
    drive(0,0,1,0,0,0,0,0); step("R1 wpt entry");  exit_debug("R7 exit");
    // R2 irq
    drive(0,1,0,1,0,0,0,0); step("R2 irq entry");  exit_debug("R7 exit");
    // R3 fiq with irq
    drive(1,0,0,1,1,0,0,0); step("R3 fiq+irq entry"); exit_debug("R7 exit");
    // R4 watchpointed abort beats both interrupts
    drive(0,0,1,1,1,1,0,0); step("R4 abort entry");
    // R6 triggers and events inside debug ignored
    drive(1,1,1,0,0,0,0,0); step("R6 retrigger");
    drive(0,0,1,1,0,1,0,0); step("R6 events in debug");
    // R8 clear inside debug
    drive(0,0,0,0,0,0,0,1); step("R8 clear");
    exit_debug("R7 exit after clear");
    // R5 abort without watchpoint not kept
    drive(1,0,0,0,0,1,0,0); step("R5 abort no wpt"); exit_debug("R7 exit");
    // R8 restart outside debug ignored
    drive(0,0,0,1,1,1,1,1); step("R8 restart idle");
    // R7 restart and new trigger together: restart then trigger ignored by exit
    drive(0,1,0,0,1,0,0,0); step("R3 fiq only");
    drive(1,0,0,0,0,0,1,0); step("R7 restart with trigger");
    drive(1,0,0,1,0,0,0,0); step("R2 reentry during tail");
    exit_debug("R7 exit");

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      halt   = ($urandom_range(0, 9) == 0);
      bkpt   = ($urandom_range(0, 9) == 0);
      wpt    = ($urandom_range(0, 7) == 0);
      irq    = $urandom_range(0, 1);
      fiq    = ($urandom_range(0, 3) == 0);
      dab    = $urandom_range(0, 1);
      rst_go = ($urandom_range(0, 5) == 0);
      clr    = ($urandom_range(0, 7) == 0);
      step("R9 random");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule